// File: doc/BRIEF.md
# Touch Sensor Burst Scheduler

This block paces the measurement bursts of a low-power capacitive touch sensor. Between bursts it waits a gap whose length depends on the current mode. In low-power mode the gap is long (nominally 80 ms). In fast mode it is short (nominally 2.6 ms). A possible-touch hint from the detection filter moves the block into fast mode, so that confirmations arrive quickly. A resolved indication, meaning the touch was confirmed or rejected, returns it to low-power mode.

Each burst is a programmable number of charge-transfer cycles. Each cycle is a charge phase (nominally 3 µs) followed by a transfer phase (nominally 6 µs). The length of every phase is dithered by up to ±7.5 percent. The offset is taken from a pseudo-random shift register, which spreads the burst's emission spectrum.

An inhibit input stops new bursts from starting, for example while an override is held. All durations are parameters in clock cycles. The analog switches are driven elsewhere from the two strobes. The interface is control only: there is no data stream and no valid/ready handshake.

Top module: `burst_sched`

## Requirements
- R1: During reset and right after it, both strobes and `burst_done` are low and `fast_mode` is 0. The first charge strobe rises exactly LP_GAP cycles after reset is released.
- R2: In low-power mode (`fast_mode`=0), exactly LP_GAP cycles with both strobes low separate the last transfer cycle of a burst from the first charge cycle of the next burst.
- R3: In fast mode (`fast_mode`=1), that separation is exactly FAST_GAP cycles.
- R4: `fast_mode` is a registered flag. A cycle with `touch_hint`=1 sets it in the following cycle. A cycle with `touch_resolved`=1 clears it in the following cycle. If both are high together, the clear wins.
- R5: The gap limit is re-evaluated every cycle from the current `fast_mode`. When the block enters fast mode during a long sleep that has already lasted FAST_GAP cycles or more, the burst starts in the cycle after `fast_mode` rises.
- R6: Each charge phase lasts between CHG_CYC−S and CHG_CYC+S cycles, where S = floor(CHG_CYC·75/1000). Each transfer phase likewise lasts between XFR_CYC−S' and XFR_CYC+S' cycles. The two strobes are never high together, and every charge phase is followed directly by a transfer phase.
- R7: Phase lengths are drawn from a nonzero pseudo-random sequence, so they vary from phase to phase across a run.
- R8: A burst contains exactly `cycles_per_burst` charge-transfer cycles. The value is sampled when the burst starts, and a value of 0 is treated as 1.
- R9: `burst_done` is high for exactly one cycle: the first cycle after the last transfer phase of a burst.
- R10: No burst starts while `inhibit`=1. A burst already in progress runs to completion. Gap counting continues under inhibit, so once the gap has elapsed the burst starts in the cycle after `inhibit` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| touch_hint | input | 1 | Detection filter reports a possible touch |
| touch_resolved | input | 1 | Possible touch confirmed or rejected |
| inhibit | input | 1 | Hold off new bursts |
| cycles_per_burst | input | CPB_W | Charge-transfer cycles per burst (0 acts as 1) |
| chg_strobe | output | 1 | High during a charge phase |
| xfr_strobe | output | 1 | High during a transfer phase |
| burst_done | output | 1 | One-cycle pulse after a burst ends |
| fast_mode | output | 1 | 1 = fast mode, 0 = low-power mode |

## Verification
A behavioural tracker predicts, every cycle, whether a gap should end on the next edge. It also measures every phase and every burst. The stimulus covers six cases:
- plain low-power sleeps;
- a hint that arrives after the fast gap has already elapsed, which separates re-evaluated limits from limits latched at burst end;
- fast-mode bursts with one, three and five cycles, where the zero setting exposes the substitution of 1;
- a simultaneous hint and resolve, which shows the priority;
- inhibit held past a full sleep, which separates a paused gap count from a running one;
- inhibit raised mid-burst, which must not shorten the burst.

The spread between the shortest and longest charge phases observed shows that the dither is active.

// File: rtl/burst_sched_pkg.sv
package burst_sched_pkg;

  typedef enum logic [1:0] {
    PH_GAP = 2'd0,
    PH_CHG = 2'd1,
    PH_XFR = 2'd2
  } phase_e;

  // Half-width of the +/-7.5 % dither window for a nominal length.
  function automatic int span_of(input int nom);
    return (nom * 75) / 1000;
  endfunction

  // Galois feedback masks for the supported register widths.
  function automatic logic [31:0] lfsr_taps(input int w);
    case (w)
      8:       return 32'h0000_00B8;
      24:      return 32'h00E1_0000;
      32:      return 32'hA300_0000;
      default: return 32'h0000_B400;
    endcase
  endfunction

endpackage

// File: rtl/bs_lfsr.sv
module bs_lfsr
  import burst_sched_pkg::*;
#(
  parameter int          W    = 16,
  parameter int unsigned SEED = 32'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);
  localparam logic [W-1:0] TAPS   = W'(lfsr_taps(W));
  localparam logic [W-1:0] SEED_W = W'(SEED);
  localparam logic [W-1:0] INIT   = (SEED_W == '0) ? W'(1) : SEED_W;

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= INIT;
    else if (step) state <= {1'b0, state[W-1:1]} ^ (state[0] ? TAPS : '0);
  end

  assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
endmodule

// File: rtl/bs_jitter.sv
module bs_jitter
  import burst_sched_pkg::*;
#(
  parameter int NOM = 40,
  parameter int OW  = 8
) (
  input  logic [7:0]    r,
  output logic [OW-1:0] len_m1
);
  localparam int SP  = span_of(NOM);
  localparam int WIN = 2 * SP + 1;

  int pick;

  // Scale the random byte onto 0..2*SP, then offset around the nominal.
  always_comb begin
    pick   = (int'({24'd0, r}) * WIN) >>> 8;
    len_m1 = OW'(NOM - SP - 1 + pick);
    assert_pick_range_R6: assert (pick >= 0 && pick <= 2 * SP);
  end
endmodule

// File: rtl/bs_mode.sv
module bs_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic hint,
  input  logic resolved,
  output logic fast
);
  always_ff @(posedge clk) begin
    if (!rst_n)        fast <= 1'b0;
    else if (resolved) fast <= 1'b0;
    else if (hint)     fast <= 1'b1;
  end

  assert_resolve_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resolved |=> !fast);
  assert_hint_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hint && !resolved) |=> fast);
endmodule

// File: rtl/burst_sched.sv
module burst_sched
  import burst_sched_pkg::*;
#(
  parameter int          CHG_CYC   = 40,
  parameter int          XFR_CYC   = 80,
  parameter int          FAST_GAP  = 100,
  parameter int          LP_GAP    = 2000,
  parameter int          CPB_W     = 8,
  parameter int          LFSR_W    = 16,
  parameter int unsigned LFSR_SEED = 32'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_hint,
  input  logic             touch_resolved,
  input  logic             inhibit,
  input  logic [CPB_W-1:0] cycles_per_burst,
  output logic             chg_strobe,
  output logic             xfr_strobe,
  output logic             burst_done,
  output logic             fast_mode
);
  localparam int PH_TOP = (CHG_CYC > XFR_CYC) ? CHG_CYC : XFR_CYC;
  localparam int PW     = $clog2(PH_TOP + span_of(PH_TOP) + 1);
  localparam int GW     = $clog2(LP_GAP + 1);
  localparam logic [GW-1:0] LP_LIM_M1   = GW'(LP_GAP - 1);
  localparam logic [GW-1:0] FAST_LIM_M1 = GW'(FAST_GAP - 1);

  phase_e           st;
  logic [PW-1:0]    cnt, chg_len_m1, xfr_len_m1;
  logic [GW-1:0]    gcnt, lim_m1;
  logic [CPB_W-1:0] left, cpb_eff;
  logic [LFSR_W-1:0] rng;
  logic             fast_q, done_q, go, chg_end, xfr_end, step;

  bs_mode u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .hint     (touch_hint),
    .resolved (touch_resolved),
    .fast     (fast_q)
  );

  bs_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED)) u_rng (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .state (rng)
  );

  bs_jitter #(.NOM(CHG_CYC), .OW(PW)) u_jit_chg (
    .r      (rng[LFSR_W-1 -: 8]),
    .len_m1 (chg_len_m1)
  );

  bs_jitter #(.NOM(XFR_CYC), .OW(PW)) u_jit_xfr (
    .r      (rng[LFSR_W-1 -: 8]),
    .len_m1 (xfr_len_m1)
  );

  always_comb begin
    lim_m1  = fast_q ? FAST_LIM_M1 : LP_LIM_M1;
    go      = (st == PH_GAP) && (gcnt >= lim_m1) && !inhibit;
    chg_end = (st == PH_CHG) && (cnt == '0);
    xfr_end = (st == PH_XFR) && (cnt == '0);
    step    = go || chg_end || (xfr_end && (left != '0));
    cpb_eff = (cycles_per_burst == '0) ? CPB_W'(1) : cycles_per_burst;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= PH_GAP;
      cnt    <= '0;
      gcnt   <= '0;
      left   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        PH_GAP: begin
          if (go) begin
            st   <= PH_CHG;
            cnt  <= chg_len_m1;
            left <= cpb_eff - 1'b1;
          end else if (gcnt < LP_LIM_M1) begin
            gcnt <= gcnt + 1'b1;
          end
        end
        PH_CHG: begin
          if (chg_end) begin
            st  <= PH_XFR;
            cnt <= xfr_len_m1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_XFR: begin
          if (xfr_end) begin
            if (left == '0) begin
              st     <= PH_GAP;
              gcnt   <= '0;
              done_q <= 1'b1;
            end else begin
              st   <= PH_CHG;
              cnt  <= chg_len_m1;
              left <= left - 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= PH_GAP;
      endcase
    end
  end

  assign chg_strobe = (st == PH_CHG);
  assign xfr_strobe = (st == PH_XFR);
  assign burst_done = done_q;
  assign fast_mode  = fast_q;

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(chg_strobe && xfr_strobe));
  assert_chg_then_xfr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chg_strobe) |-> xfr_strobe);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);
  assert_done_after_xfr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> ($past(xfr_strobe) && !xfr_strobe && !chg_strobe));
  assert_no_start_inhibit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(chg_strobe) && !$past(xfr_strobe)) |-> !$past(inhibit));
endmodule

// File: tb/burst_sched_tb.sv
module burst_sched_tb;
  localparam int CHG = 40, XFR = 80, FASTG = 100, LPG = 2000;
  localparam int SC = (CHG * 75) / 1000;
  localparam int SX = (XFR * 75) / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic touch_hint = 1'b0, touch_resolved = 1'b0, inhibit = 1'b0;
  logic [7:0] cycles_per_burst = 8'd3;
  logic chg_strobe, xfr_strobe, burst_done, fast_mode;

  always #4 clk = ~clk;

  burst_sched u_dut (
    .clk(clk), .rst_n(rst_n), .touch_hint(touch_hint),
    .touch_resolved(touch_resolved), .inhibit(inhibit),
    .cycles_per_burst(cycles_per_burst), .chg_strobe(chg_strobe),
    .xfr_strobe(xfr_strobe), .burst_done(burst_done), .fast_mode(fast_mode)
  );

  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  // Behavioural tracker, sampled 1 ns after each falling edge.
  bit mon_on = 0, pred_valid = 0, pred_start = 0, exp_mode = 0;
  int ph_prev = 0, run = 0, g = 0, cyc_cnt = 0, exp_cyc = 0;
  int cmin = 1000, cmax = 0;

  always begin
    @(negedge clk);
    #1;
    if (mon_on) begin
      int o;
      int lim;
      o = chg_strobe ? 1 : (xfr_strobe ? 2 : 0);
      chk(!(chg_strobe && xfr_strobe), "R6 strobe overlap", 1, 0);
      chk(fast_mode == exp_mode, "R4 mode flag", int'(fast_mode), int'(exp_mode));
      exp_mode = touch_resolved ? 1'b0 : (touch_hint ? 1'b1 : exp_mode);
      chk(burst_done == (ph_prev == 2 && o == 0), "R9 done pulse", int'(burst_done),
          int'(ph_prev == 2 && o == 0));
      if (pred_valid)
        chk((o == 1) == pred_start, "R2 R3 R5 R10 burst start", int'(o == 1), int'(pred_start));
      pred_valid = 0;
      if (o != ph_prev) begin
        if (ph_prev == 1) begin
          chk(run >= CHG - SC && run <= CHG + SC, "R6 charge length", run, CHG);
          chk(o == 2, "R6 charge then transfer", o, 2);
          if (run < cmin) cmin = run;
          if (run > cmax) cmax = run;
          cyc_cnt++;
        end
        if (ph_prev == 2) begin
          chk(run >= XFR - SX && run <= XFR + SX, "R6 transfer length", run, XFR);
          if (o == 0) chk(cyc_cnt == exp_cyc, "R8 cycles per burst", cyc_cnt, exp_cyc);
        end
        run = 0;
      end
      run++;
      if (o == 0) begin
        if (ph_prev != 0) g = 0;
        g++;
        lim = fast_mode ? FASTG : LPG;
        pred_start = (g >= lim) && !inhibit;
        pred_valid = 1;
        if (pred_start) begin
          exp_cyc = (cycles_per_burst == 0) ? 1 : int'(cycles_per_burst);
          cyc_cnt = 0;
        end
      end
      ph_prev = o;
    end
  end

  task automatic wait_done(input int n);
    repeat (n) begin
      do @(negedge clk); while (!burst_done);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int t;
    idle(5);
    chk(!chg_strobe && !xfr_strobe && !burst_done && !fast_mode, "R1 reset outputs",
        int'({chg_strobe, xfr_strobe, burst_done, fast_mode}), 0);
    rst_n  = 1'b1;
    mon_on = 1;
    t = 0;
    while (!chg_strobe) begin
      @(negedge clk);
      t++;
    end
    chk(t == LPG, "R1 first burst delay", t, LPG);

    wait_done(2);                    // R2 low-power sleeps, R8 three cycles
    idle(200);                       // past FAST_GAP inside a long sleep: R5
    touch_hint = 1'b1; idle(1); touch_hint = 1'b0;
    wait_done(3);                    // R3 fast gaps
    cycles_per_burst = 8'd0;         // R8 zero acts as one
    wait_done(2);
    cycles_per_burst = 8'd5;
    wait_done(2);
    idle(20);
    touch_hint = 1'b1; touch_resolved = 1'b1;   // R4 clear wins
    idle(1);
    touch_hint = 1'b0; touch_resolved = 1'b0;
    wait_done(1);
    inhibit = 1'b1;                  // R10 held past a full sleep
    idle(LPG + 500);
    inhibit = 1'b0;
    wait_done(1);
    while (!chg_strobe) @(negedge clk);
    inhibit = 1'b1;                  // R10 raised mid-burst
    wait_done(1);
    idle(LPG + 300);
    inhibit = 1'b0;
    wait_done(1);
    idle(5);
    chk(cmax > cmin, "R7 dithered charge lengths", cmax - cmin, 1);
    finish_run();
  end
endmodule